// File: doc/BRIEF.md
# Parallel ROM Read Controller

This block lets a requester inside a synchronous design read single bytes from an external, asynchronous 256K x 8 mask ROM. A request carries an 18-bit address. The controller registers that address onto the ROM address pins. It asserts the active-low chip enable and the two output-enable lines. It then counts system-clock cycles until the slowest of the address, chip-enable and output-enable access intervals has elapsed. On that edge it captures the ROM byte and returns it with a one-cycle valid pulse.

Every wait is derived from a time in picoseconds divided by the clock period, rounded up. After the capture, the enables are withdrawn and the controller holds off further requests. It does so until the ROM outputs have had time to float and the minimum read cycle time has passed. Each output-enable line has its own mode parameter: active high, active low, or ignored. An ignored line is parked at a fixed low level. A standby parameter chooses between two behaviours. In the first, chip enable is released whenever the controller is idle, so every read pays the full chip-enable access time. In the second, chip enable stays asserted from reset onward, and only the time since reset counts toward it.

Top module: `prom_reader`

## Requirements
- R1: While reset is asserted, the outputs are as follows: reqReady is 1, rspValid is 0 and rspData is 0. romAddr is 0. Both output-enable lines are at their inactive level, which is 0 for an ignored line. romCeN is 1 with standby enabled and 0 with standby disabled.
- R2: A request is accepted on a clock edge where reqValid and reqReady are both 1. romAddr takes reqAddr on that edge. reqReady is 0 from that edge until the release interval ends, and romAddr does not change during that time.
- R3: Each wait count is the corresponding time divided by CLK_PS, rounded up, with a minimum of 1. With the defaults, the address wait is 30 cycles, the chip-enable wait is 30, the output-enable wait is 14, the float wait is 14 and the read-cycle wait is 30.
- R4: If the accept edge is n, the byte is captured on edge n+W. W is the largest of the address wait, the output-enable wait and the chip-enable cycles still outstanding. rspValid is 1 for exactly the one cycle after edge n+W. rspData holds the captured byte until the next capture.
- R5: With STANDBY=1, romCeN is 0 from the accept edge to the capture edge and 1 at all other times. The chip-enable wait restarts from its full value on every accept.
- R6: With STANDBY=0, romCeN is 0 at all times, including during reset. The chip-enable wait runs once, from reset release, so a request made soon after reset waits for the cycles that remain.
- R7: An output-enable line in mode OE_HIGH (encoding 0) is 1 from the accept edge to the capture edge and 0 otherwise. A line in mode OE_LOW (encoding 1) has the opposite levels. The capture edge always falls inside that window.
- R8: An output-enable line in mode OE_IGNORE (encoding 2) is held at 0 at all times.
- R9: reqReady returns to 1 after edge n + max(W + float wait, read-cycle wait).
- R10: rspData equals the ROM byte stored at the accepted address, for every combination of output-enable modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Controller idle, request can be taken |
| reqAddr | input | ADDR_W | Byte address of the request |
| rspValid | output | 1 | One-cycle pulse with the read byte |
| rspData | output | DATA_W | Captured ROM byte |
| romAddr | output | ADDR_W | Address pins to the ROM |
| romCeN | output | 1 | Chip enable to the ROM, active low |
| romOe0 | output | 1 | First output-enable line, level per OE0_MODE |
| romOe1 | output | 1 | Second output-enable line, level per OE1_MODE |
| romData | input | DATA_W | Data pins from the ROM |

## Verification
Several properties are checked on every cycle:
- The response is a single-cycle pulse.
- reqReady drops after an accept, and the ROM address holds still while busy.
- No capture happens before the address and output-enable waits have elapsed, or while the enables are off.
- reqReady never returns before the float interval.
- Ignored lines stay parked, and chip enable behaves as the standby mode requires.

Other behaviours can only be shown by the bench scenarios, because they need a delayed-output model of the ROM that returns corrupted data until every access interval has elapsed:
- the exact capture cycle, including the rounding up of the wait counts;
- the longer first read after reset without standby;
- correct data for all six output-enable mode combinations.

// File: rtl/prom_reader_pkg.sv
package prom_reader_pkg;

  // Output-enable line behaviour; encodings are part of the block's contract
  typedef enum logic [1:0] {
    OE_HIGH   = 2'd0,
    OE_LOW    = 2'd1,
    OE_IGNORE = 2'd2
  } oeMode_e;

  // Strobes and levels passed from the control to the datapath
  typedef struct packed {
    logic accept;   // request taken on this edge
    logic sample;   // capture ROM data on this edge
    logic ceOn;     // chip enable asserted
    logic oeOn;     // output enables asserted
  } ctrlStrobe_t;

  // Cycles needed to cover a time, rounded up, never below one
  function automatic int cyclesFor(input int timePs, input int clkPs);
    int c;
    c = (timePs + clkPs - 1) / clkPs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/prom_reader_tmr.sv
// Down-counter that reports expiry; reloads on request, saturates at zero
module prom_reader_tmr #(
  parameter int W    = 6,
  parameter int LOAD = 1,
  parameter int INIT = 0
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic expired
);
  localparam logic [W-1:0] LOAD_V = W'(LOAD);
  localparam logic [W-1:0] INIT_V = W'(INIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= INIT_V;
    else if (load)          cnt <= LOAD_V;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/prom_reader_pin.sv
// Encodes an "enable on" request onto a pin according to its mode
module prom_reader_pin
  import prom_reader_pkg::*;
#(
  parameter oeMode_e MODE = OE_LOW
) (
  input  logic on,
  output logic pin
);
  generate
    if (MODE == OE_HIGH) begin : g_high
      assign pin = on;
    end else if (MODE == OE_LOW) begin : g_low
      assign pin = ~on;
    end else begin : g_park
      logic unusedOn;
      assign unusedOn = on;
      assign pin = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/prom_reader_ctrl.sv
module prom_reader_ctrl
  import prom_reader_pkg::*;
#(
  parameter int AA_CYC  = 30,
  parameter int ACE_CYC = 30,
  parameter int OE_CYC  = 14,
  parameter int HZ_CYC  = 14,
  parameter int RC_CYC  = 30,
  parameter bit STANDBY = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output ctrlStrobe_t strb
);
  localparam int MAX_AB  = (AA_CYC > ACE_CYC) ? AA_CYC : ACE_CYC;
  localparam int MAX_OH  = (OE_CYC > HZ_CYC) ? OE_CYC : HZ_CYC;
  localparam int MAX_ABO = (MAX_AB > MAX_OH) ? MAX_AB : MAX_OH;
  localparam int MAX_CYC = (MAX_ABO > RC_CYC) ? MAX_ABO : RC_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_RELEASE} state_e;

  state_e state;
  logic   accept, accessDone, releaseDone;
  logic   addrExp, ceExp, oeExp, hzExp, rcExp;
  logic   ceOnQ, oeOnQ;

  assign accept      = (state == ST_IDLE) && reqValid;
  assign accessDone  = (state == ST_ACCESS) && addrExp && ceExp && oeExp;
  assign releaseDone = (state == ST_RELEASE) && hzExp && rcExp;

  // Address-to-data interval, from the accept edge
  prom_reader_tmr #(.W(CNT_W), .LOAD(AA_CYC - 1), .INIT(0)) u_addrTmr (
    .clk(clk), .rstN(rstN), .load(accept), .expired(addrExp));

  // Chip-enable interval: restarted per request in standby, else from reset
  prom_reader_tmr #(.W(CNT_W), .LOAD(ACE_CYC - 1),
                    .INIT(STANDBY ? 0 : ACE_CYC - 1)) u_ceTmr (
    .clk(clk), .rstN(rstN), .load(accept && STANDBY), .expired(ceExp));

  // Output-enable interval, from the accept edge
  prom_reader_tmr #(.W(CNT_W), .LOAD(OE_CYC - 1), .INIT(0)) u_oeTmr (
    .clk(clk), .rstN(rstN), .load(accept), .expired(oeExp));

  // Bus float interval, from the capture edge
  prom_reader_tmr #(.W(CNT_W), .LOAD(HZ_CYC - 1), .INIT(0)) u_hzTmr (
    .clk(clk), .rstN(rstN), .load(accessDone), .expired(hzExp));

  // Minimum read cycle, from the accept edge
  prom_reader_tmr #(.W(CNT_W), .LOAD(RC_CYC - 1), .INIT(0)) u_rcTmr (
    .clk(clk), .rstN(rstN), .load(accept), .expired(rcExp));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ceOnQ <= !STANDBY;
      oeOnQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:    if (accept)      state <= ST_ACCESS;
        ST_ACCESS:  if (accessDone)  state <= ST_RELEASE;
        ST_RELEASE: if (releaseDone) state <= ST_IDLE;
        default:                     state <= ST_IDLE;
      endcase
      if (accept)          oeOnQ <= 1'b1;
      else if (accessDone) oeOnQ <= 1'b0;
      if (STANDBY) begin
        if (accept)          ceOnQ <= 1'b1;
        else if (accessDone) ceOnQ <= 1'b0;
      end
    end
  end

  assign reqReady    = (state == ST_IDLE);
  assign strb.accept = accept;
  assign strb.sample = accessDone;
  assign strb.ceOn   = ceOnQ;
  assign strb.oeOn   = oeOnQ;
endmodule

// File: rtl/prom_reader_dp.sv
module prom_reader_dp
  import prom_reader_pkg::*;
#(
  parameter int      ADDR_W   = 18,
  parameter int      DATA_W   = 8,
  parameter oeMode_e OE0_MODE = OE_LOW,
  parameter oeMode_e OE1_MODE = OE_IGNORE
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOe0,
  output logic              romOe1,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romAddr  <= '0;
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      if (strb.accept) romAddr <= reqAddr;
      if (strb.sample) rspData <= romData;
      rspValid <= strb.sample;
    end
  end

  assign romCeN = ~strb.ceOn;

  prom_reader_pin #(.MODE(OE0_MODE)) u_pin0 (.on(strb.oeOn), .pin(romOe0));
  prom_reader_pin #(.MODE(OE1_MODE)) u_pin1 (.on(strb.oeOn), .pin(romOe1));
endmodule

// File: rtl/prom_reader.sv
module prom_reader
  import prom_reader_pkg::*;
#(
  parameter int      ADDR_W    = 18,
  parameter int      DATA_W    = 8,
  parameter int      CLK_PS    = 5000,
  parameter int      T_AA_PS   = 150000,
  parameter int      T_ACE_PS  = 150000,
  parameter int      T_OE_PS   = 70000,
  parameter int      T_HZ_PS   = 70000,
  parameter int      T_RC_PS   = 150000,
  parameter oeMode_e OE0_MODE  = OE_LOW,
  parameter oeMode_e OE1_MODE  = OE_IGNORE,
  parameter bit      STANDBY   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOe0,
  output logic              romOe1,
  input  logic [DATA_W-1:0] romData
);
  localparam int AA_CYC  = cyclesFor(T_AA_PS, CLK_PS);
  localparam int ACE_CYC = cyclesFor(T_ACE_PS, CLK_PS);
  localparam int OE_CYC  = cyclesFor(T_OE_PS, CLK_PS);
  localparam int HZ_CYC  = cyclesFor(T_HZ_PS, CLK_PS);
  localparam int RC_CYC  = cyclesFor(T_RC_PS, CLK_PS);

  ctrlStrobe_t strb;

  prom_reader_ctrl #(
    .AA_CYC(AA_CYC), .ACE_CYC(ACE_CYC), .OE_CYC(OE_CYC),
    .HZ_CYC(HZ_CYC), .RC_CYC(RC_CYC), .STANDBY(STANDBY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqReady(reqReady), .strb(strb)
  );

  prom_reader_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OE0_MODE(OE0_MODE), .OE1_MODE(OE1_MODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .romData(romData), .romAddr(romAddr), .romCeN(romCeN),
    .romOe0(romOe0), .romOe1(romOe1), .rspValid(rspValid),
    .rspData(rspData)
  );
endmodule

// File: rtl/prom_reader_chk.sv
module prom_reader_chk
  import prom_reader_pkg::*;
#(
  parameter int      ADDR_W   = 18,
  parameter int      CLK_PS   = 5000,
  parameter int      T_AA_PS  = 150000,
  parameter int      T_OE_PS  = 70000,
  parameter int      T_HZ_PS  = 70000,
  parameter oeMode_e OE0_MODE = OE_LOW,
  parameter oeMode_e OE1_MODE = OE_IGNORE,
  parameter bit      STANDBY  = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] romAddr,
  input logic              romCeN,
  input logic              romOe0,
  input logic              romOe1
);
  localparam int AA_C   = cyclesFor(T_AA_PS, CLK_PS);
  localparam int OE_C   = cyclesFor(T_OE_PS, CLK_PS);
  localparam int HZ_C   = cyclesFor(T_HZ_PS, CLK_PS);
  localparam int MIN_W  = (AA_C > OE_C) ? AA_C : OE_C;
  localparam bit NO_GATE = !STANDBY && (OE0_MODE == OE_IGNORE) && (OE1_MODE == OE_IGNORE);

  logic        oe0Act, oe1Act, driveOn;
  logic [15:0] accAge, offAge;

  assign oe0Act  = (OE0_MODE == OE_HIGH) ? romOe0 : (OE0_MODE == OE_LOW) ? !romOe0 : 1'b1;
  assign oe1Act  = (OE1_MODE == OE_HIGH) ? romOe1 : (OE1_MODE == OE_LOW) ? !romOe1 : 1'b1;
  assign driveOn = !romCeN && oe0Act && oe1Act;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accAge <= '0;
      offAge <= '0;
    end else begin
      if (reqValid && reqReady)  accAge <= '0;
      else if (accAge != 16'hFFFF) accAge <= accAge + 1'b1;
      if (driveOn)               offAge <= '0;
      else if (offAge != 16'hFFFF) offAge <= offAge + 1'b1;
    end
  end

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(romAddr));

  // R4
  wait_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (accAge >= 16'(MIN_W)));

  // R7
  sample_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(driveOn));

  generate
    if (!NO_GATE) begin : g_float
      // R9
      float_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(reqReady) |-> (offAge >= 16'(HZ_C)));
    end
    if (OE0_MODE == OE_IGNORE) begin : g_park0
      // R8
      park0_chk: assert property (@(posedge clk) disable iff (!rstN) !romOe0);
    end
    if (OE1_MODE == OE_IGNORE) begin : g_park1
      // R8
      park1_chk: assert property (@(posedge clk) disable iff (!rstN) !romOe1);
    end
    if (STANDBY) begin : g_stby
      // R5
      idle_ce_off_chk: assert property (@(posedge clk) disable iff (!rstN)
        reqReady |-> romCeN);
    end else begin : g_awake
      // R6
      ce_held_chk: assert property (@(posedge clk) disable iff (!rstN) !romCeN);
    end
  endgenerate
endmodule

bind prom_reader prom_reader_chk #(
  .ADDR_W(ADDR_W), .CLK_PS(CLK_PS), .T_AA_PS(T_AA_PS), .T_OE_PS(T_OE_PS),
  .T_HZ_PS(T_HZ_PS), .OE0_MODE(OE0_MODE), .OE1_MODE(OE1_MODE), .STANDBY(STANDBY)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .romAddr(romAddr), .romCeN(romCeN),
  .romOe0(romOe0), .romOe1(romOe1)
);

// File: tb/prom_reader_bench.sv
package prom_reader_tb_pkg;
  function automatic logic [7:0] romByte(input logic [17:0] a);
    return a[7:0] ^ {a[15:12], a[11:8]} ^ {a[17:16], 6'b0} ^ 8'h3C;
  endfunction
  function automatic int cdiv(input int t, input int p);
    int c;
    c = (t + p - 1) / p;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic logic enc(input int mode, input logic on);
    return (mode == 0) ? on : (mode == 1) ? !on : 1'b0;
  endfunction
endpackage

// Behavioural ROM: data is corrupted until every access interval has elapsed
module prom_rom_model #(
  parameter int     M0    = 1,
  parameter int     M1    = 2,
  parameter longint T_AA  = 150000,
  parameter longint T_ACE = 150000,
  parameter longint T_OE  = 70000
) (
  input  logic [17:0] addr,
  input  logic        ceN,
  input  logic        oe0,
  input  logic        oe1,
  output logic [7:0]  data
);
  import prom_reader_tb_pkg::*;
  longint tA = 0, tC = 0, tG = 0;
  logic   gate;
  assign gate = ((M0 == 0) ? oe0 : (M0 == 1) ? !oe0 : 1'b1) &&
                ((M1 == 0) ? oe1 : (M1 == 1) ? !oe1 : 1'b1);
  always @(addr)         tA = $time;
  always @(negedge ceN)  tC = $time;
  always @(posedge gate) tG = $time;
  initial begin
    data = 8'h00;
    #250;
    forever begin
      if (!ceN && gate && ($time - tA >= T_AA - 500) &&
          ($time - tC >= T_ACE - 500) && ($time - tG >= T_OE - 500))
        data = romByte(addr);
      else
        data = ~romByte(addr);
      #500;
    end
  end
endmodule

// Reference for one controller, by edge numbers counted from reset release
module prom_ref #(
  parameter int AA = 30, OE = 14, ACE = 30, HZ = 14, RC = 30,
  parameter bit STBY = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        req,
  input  logic [17:0] addr,
  output logic        eReady,
  output logic        eValid,
  output logic        eCe,
  output logic        eOe,
  output logic [17:0] eAddr,
  output logic [7:0]  eData
);
  import prom_reader_tb_pkg::*;
  int edgeNo, validEdge, freeEdge, phase, w, ceLeft;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeNo = 0; phase = 0; eReady = 1; eValid = 0;
      eCe = !STBY; eOe = 0; eAddr = '0; eData = '0;
    end else begin
      edgeNo++;
      eValid = 0;
      if (phase == 1 && edgeNo == validEdge) begin
        eValid = 1; eData = romByte(eAddr); phase = 2; eOe = 0;
        if (STBY) eCe = 0;
      end else if (phase == 2 && edgeNo == freeEdge) begin
        phase = 0;
      end else if (phase == 0 && req) begin
        ceLeft = STBY ? ACE : ((ACE - edgeNo > 0) ? ACE - edgeNo : 0);
        w = (AA > OE) ? AA : OE;
        if (ceLeft > w) w = ceLeft;
        eAddr = addr;
        validEdge = edgeNo + w;
        freeEdge = edgeNo + ((w + HZ > RC) ? w + HZ : RC);
        phase = 1; eOe = 1; eCe = 1;
      end
      eReady = (phase == 0);
    end
  end
endmodule

module prom_reader_bench;
  import prom_reader_pkg::*;
  import prom_reader_tb_pkg::*;

  localparam int CLK_PS = 5000;
  localparam int AA  = cdiv(150000, CLK_PS);
  localparam int ACE = cdiv(150000, CLK_PS);
  localparam int OE  = cdiv(70000, CLK_PS);
  localparam int HZ  = cdiv(70000, CLK_PS);
  localparam int RC  = cdiv(150000, CLK_PS);
  localparam int ACE2 = cdiv(197000, CLK_PS);

  logic clk = 0, rstN = 0;
  int   checks = 0, errors = 0, cyc = 0, rspCount = 0, accEdge = 0;
  bit   finished = 0;

  // Main (standby) controller
  logic        reqValid = 0, reqReady, rspValid, romCeN, romOe0, romOe1;
  logic [17:0] reqAddr = '0, romAddr;
  logic [7:0]  rspData, romData;
  // Controller with chip enable held
  logic        req2 = 0, rdy2, val2, ceN2, oe0b, oe1b;
  logic [17:0] addr2 = '0, romAddr2;
  logic [7:0]  data2, romData2;
  // Mode combinations sharing the main request
  logic        cReady[6], cValid[6], cCeN[6], cOe0[6], cOe1[6];
  logic [17:0] cAddr[6];
  logic [7:0]  cData[6], cRom[6];
  // Expected values
  logic        eReady, eValid, eCe, eOe, eReady2, eValid2, eCe2, eOe2;
  logic [17:0] eAddr, eAddr2;
  logic [7:0]  eData, eData2;

  always #2500 clk = ~clk;

  prom_reader #(.CLK_PS(CLK_PS)) u_prom_reader (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspData(rspData),
    .romAddr(romAddr), .romCeN(romCeN), .romOe0(romOe0), .romOe1(romOe1),
    .romData(romData));
  prom_rom_model #(.M0(1), .M1(2)) u_rom (
    .addr(romAddr), .ceN(romCeN), .oe0(romOe0), .oe1(romOe1), .data(romData));
  prom_ref #(.AA(AA), .OE(OE), .ACE(ACE), .HZ(HZ), .RC(RC), .STBY(1)) u_ref (
    .clk(clk), .rstN(rstN), .req(reqValid), .addr(reqAddr), .eReady(eReady),
    .eValid(eValid), .eCe(eCe), .eOe(eOe), .eAddr(eAddr), .eData(eData));

  prom_reader #(.CLK_PS(CLK_PS), .T_ACE_PS(197000), .STANDBY(1'b0)) u_awake (
    .clk(clk), .rstN(rstN), .reqValid(req2), .reqReady(rdy2),
    .reqAddr(addr2), .rspValid(val2), .rspData(data2),
    .romAddr(romAddr2), .romCeN(ceN2), .romOe0(oe0b), .romOe1(oe1b),
    .romData(romData2));
  prom_rom_model #(.M0(1), .M1(2), .T_ACE(197000)) u_rom2 (
    .addr(romAddr2), .ceN(ceN2), .oe0(oe0b), .oe1(oe1b), .data(romData2));
  prom_ref #(.AA(AA), .OE(OE), .ACE(ACE2), .HZ(HZ), .RC(RC), .STBY(0)) u_ref2 (
    .clk(clk), .rstN(rstN), .req(req2), .addr(addr2), .eReady(eReady2),
    .eValid(eValid2), .eCe(eCe2), .eOe(eOe2), .eAddr(eAddr2), .eData(eData2));

  for (genvar g = 0; g < 6; g++) begin : g_combo
    prom_reader #(.CLK_PS(CLK_PS), .OE0_MODE(oeMode_e'(g % 2)),
                  .OE1_MODE(oeMode_e'(g / 2))) u_dut (
      .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(cReady[g]),
      .reqAddr(reqAddr), .rspValid(cValid[g]), .rspData(cData[g]),
      .romAddr(cAddr[g]), .romCeN(cCeN[g]), .romOe0(cOe0[g]),
      .romOe1(cOe1[g]), .romData(cRom[g]));
    prom_rom_model #(.M0(g % 2), .M1(g / 2)) u_rom (
      .addr(cAddr[g]), .ceN(cCeN[g]), .oe0(cOe0[g]), .oe1(cOe1[g]),
      .data(cRom[g]));
  end

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      chk(0, "watchdog", cyc, 50000);
      report();
    end
  end

  // Per-cycle comparison against the references, away from the active edge
  always @(negedge clk) begin
    chk(reqReady == eReady, "R2/R9 ready", reqReady, eReady);
    chk(rspValid == eValid, "R4 valid", rspValid, eValid);
    chk(rspData == eData, "R10 data", rspData, eData);
    chk(romAddr == eAddr, "R2 romAddr", romAddr, eAddr);
    chk(romCeN == !eCe, "R5 ceN", romCeN, !eCe);
    chk(romOe0 == enc(1, eOe), "R7 oe0", romOe0, enc(1, eOe));
    chk(romOe1 == 1'b0, "R8 oe1 parked", romOe1, 0);
    chk(rdy2 == eReady2, "R6 ready no-standby", rdy2, eReady2);
    chk(val2 == eValid2, "R6 valid no-standby", val2, eValid2);
    chk(data2 == eData2, "R10 data no-standby", data2, eData2);
    chk(ceN2 == 1'b0, "R6 ceN held", ceN2, 0);
    for (int i = 0; i < 6; i++) begin
      chk(cOe0[i] == enc(i % 2, eOe), "R7 combo oe0", cOe0[i], enc(i % 2, eOe));
      chk(cOe1[i] == enc(i / 2, eOe), "R7/R8 combo oe1", cOe1[i], enc(i / 2, eOe));
      chk(cValid[i] == eValid, "R4 combo valid", cValid[i], eValid);
      chk(cData[i] == eData, "R10 combo data", cData[i], eData);
    end
    if (rstN && reqValid && reqReady) accEdge = cyc + 1;
    if (rstN && rspValid) begin
      rspCount++;
      // R3: latency equals the rounded-up address wait, the largest here
      chk(cyc - accEdge == AA, "R3 latency", cyc - accEdge, AA);
    end
  end

  task automatic mainReq(input logic [17:0] a, input bit drop);
    reqValid = 1; reqAddr = a;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    if (drop) reqValid = 0;
  endtask

  task automatic awakeReq(input logic [17:0] a);
    req2 = 1; addr2 = a;
    while (!rdy2) @(negedge clk);
    @(negedge clk);
    req2 = 0;
  endtask

  initial begin
    logic [17:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(reqReady == 1 && rspValid == 0 && rspData == 0, "R1 handshake", {reqReady, rspValid}, 2'b10);
    chk(romAddr == 0 && romCeN == 1, "R1 rom pins", {romAddr, romCeN}, 1);
    chk(romOe0 == 1 && romOe1 == 0, "R1 oe levels", {romOe0, romOe1}, 2'b10);
    chk(ceN2 == 0, "R1/R6 ce held in reset", ceN2, 0);
    rstN = 1;
    fork
      begin
        mainReq(18'h00000, 1);
        mainReq(18'h3FFFF, 1);
        mainReq(18'h15555, 0);
        mainReq(18'h2AAAA, 0);
        mainReq(18'h10203, 1);
        repeat (7) @(negedge clk);
        lfsr = 18'h2B3C1;
        for (int k = 0; k < 7; k++) begin
          lfsr = {lfsr[16:0], lfsr[17] ^ lfsr[10]};
          mainReq(lfsr, k % 2 == 0);
        end
        reqValid = 0;
      end
      begin
        awakeReq(18'h00123);
        awakeReq(18'h3FF00);
        repeat (3) @(negedge clk);
        awakeReq(18'h2AAAA);
      end
    join
    repeat (80) @(negedge clk);
    // R4: one response per request
    chk(rspCount == 12, "R4 response count", rspCount, 12);
    finished = 1;
    report();
  end
endmodule